// File: doc/BRIEF.md
# Dual-Port SDRAM Request Arbiter

This block sits in front of the SDRAM timing engine and serves two request sources: a video port that fetches fixed 16-word read bursts, and a main system-bus port that reads or writes one quad-word (four 32-bit words) per request. When both ports ask in the same cycle the video port is granted. A granted request is turned into a single burst command with a start address and a beat count for a 16-bit memory data path. Each 32-bit word moves as two 16-bit beats.

Video reads are packed back into 32-bit words and handed out one word per pulse. Main reads are gathered into a 128-bit result. Main writes are latched at acceptance and sent out beat by beat. Each port receives a one-cycle done pulse when its burst completes. Arbitration happens only while no burst is in flight, so a running burst is never cut short.

Top module: `sdram_dual_arb`

## Requirements
- R1: After reset, cmd_valid, mem_wvalid, vid_rvalid, vid_done and main_done are all low.
- R2: When the block is idle and vid_valid and main_valid are both high, vid_ready is high and main_ready is low, so the video request is accepted first.
- R3: An accepted video request issues one read command (cmd_write = 0) with cmd_len = 32 beats and cmd_addr = vid_addr * 2, which is a beat address.
- R4: Only the vid_addr value sampled at acceptance is used. Changes to vid_addr after acceptance do not change cmd_addr or the returned data.
- R5: An accepted main request issues one command with cmd_len = 8 beats and cmd_write = main_write. The address is forced to a quad-word boundary: cmd_addr = {main_addr with its two low bits cleared} * 2.
- R6: Within each 32-bit word the low 16-bit half is moved first. A main write sends beat k from main_wdata[16k+15:16k], for k = 0 to 7. Video word i is assembled as {beat 2i+1, beat 2i}.
- R7: From acceptance until the done pulse, vid_ready and main_ready both stay low, whatever requests are present.
- R8: Each burst produces exactly one done pulse, and only on the port that owns the burst. A video burst produces exactly 16 vid_rvalid pulses, and the last one coincides with vid_done.
- R9: When main_done pulses after a main read, main_rdata[16k+15:16k] holds read beat k, for k = 0 to 7.
- R10: While cmd_valid is high and cmd_ready is low, cmd_valid stays high and cmd_addr and cmd_len hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vid_valid | input | 1 | Video burst request |
| vid_ready | output | 1 | Video request accepted this cycle |
| vid_addr | input | WADDR_W | Video start address, counted in 32-bit words |
| vid_rdata | output | 32 | Video read word |
| vid_rvalid | output | 1 | vid_rdata holds a valid word |
| vid_done | output | 1 | Video burst finished |
| main_valid | input | 1 | Main quad-word request |
| main_ready | output | 1 | Main request accepted this cycle |
| main_write | input | 1 | 1 = write, 0 = read |
| main_addr | input | WADDR_W | Main address, counted in 32-bit words |
| main_wdata | input | 128 | Main write data, word 0 in the low bits |
| main_rdata | output | 128 | Main read data, valid while main_done is high |
| main_done | output | 1 | Main access finished |
| cmd_valid | output | 1 | Burst command valid |
| cmd_ready | input | 1 | Command taken by the timing engine |
| cmd_write | output | 1 | Command direction |
| cmd_addr | output | WADDR_W+1 | Start address, counted in 16-bit beats |
| cmd_len | output | 6 | Beat count, 32 or 8 |
| mem_wdata | output | 16 | Write beat |
| mem_wvalid | output | 1 | Write beat valid |
| mem_wready | input | 1 | Write beat taken |
| mem_rdata | input | 16 | Read beat |
| mem_rvalid | input | 1 | Read beat valid |

## Verification
The bench raises both requests in the same idle cycle and keeps the main request up for the whole video burst. A design that granted main first, or granted it in the middle of the burst, would show the wrong command order or a main_ready pulse before vid_done. After every video acceptance the bench changes vid_addr to a random value, which catches a design that reads the live address instead of the captured one. Main requests use unaligned addresses and addresses at the top of the range, so a missing quad-word alignment or a wrong beat-address shift shows up as a wrong cmd_addr. The bench compares every beat against values it computes itself, so a swapped half-word order would show up as corrupted video words, main_rdata or write beats. The memory model stalls cmd_ready, mem_wready and mem_rvalid at random, which exposes beat miscounts and missing or doubled done pulses.

// File: rtl/sdram_dual_arb.sv
module sdram_dual_arb #(
  parameter int WADDR_W    = 24,
  parameter int VID_WORDS  = 16,
  parameter int QUAD_WORDS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 vid_valid,
  output logic                 vid_ready,
  input  logic [WADDR_W-1:0]   vid_addr,
  output logic [31:0]          vid_rdata,
  output logic                 vid_rvalid,
  output logic                 vid_done,
  input  logic                 main_valid,
  output logic                 main_ready,
  input  logic                 main_write,
  input  logic [WADDR_W-1:0]   main_addr,
  input  logic [32*QUAD_WORDS-1:0] main_wdata,
  output logic [32*QUAD_WORDS-1:0] main_rdata,
  output logic                 main_done,
  output logic                 cmd_valid,
  input  logic                 cmd_ready,
  output logic                 cmd_write,
  output logic [WADDR_W:0]     cmd_addr,
  output logic [$clog2(2*VID_WORDS+1)-1:0] cmd_len,
  output logic [15:0]          mem_wdata,
  output logic                 mem_wvalid,
  input  logic                 mem_wready,
  input  logic [15:0]          mem_rdata,
  input  logic                 mem_rvalid
);
  localparam int BW    = 16;
  localparam int VB    = 2 * VID_WORDS;
  localparam int MB    = 2 * QUAD_WORDS;
  localparam int LEN_W = $clog2(VB + 1);
  localparam int QA    = $clog2(QUAD_WORDS);
  localparam int MBI_W = $clog2(MB);

  typedef enum logic [1:0] {IDLE, CMD, DATA} st_t;

  st_t                 state;
  logic                sel_vid;
  logic                wr_q;
  logic [WADDR_W:0]    addr_q;
  logic [LEN_W-1:0]    cnt;
  logic [BW-1:0]       half_q;
  logic [32*QUAD_WORDS-1:0] wbuf;
  logic [32*QUAD_WORDS-1:0] rbuf;
  logic [31:0]         vword_q;
  logic                vrv_q, vdone_q, mdone_q;

  logic [LEN_W-1:0]    burst_len;
  logic                beat, last;

  assign burst_len  = sel_vid ? LEN_W'(VB) : LEN_W'(MB);
  assign beat       = (state == DATA) && (wr_q ? mem_wready : mem_rvalid);
  assign last       = beat && (cnt == burst_len - 1'b1);

  assign vid_ready  = (state == IDLE) && vid_valid;
  assign main_ready = (state == IDLE) && main_valid && !vid_valid;

  assign cmd_valid  = (state == CMD);
  assign cmd_write  = wr_q;
  assign cmd_addr   = addr_q;
  assign cmd_len    = burst_len;

  assign mem_wvalid = (state == DATA) && wr_q;
  assign mem_wdata  = wbuf[int'(cnt[MBI_W-1:0])*BW +: BW];

  assign vid_rdata  = vword_q;
  assign vid_rvalid = vrv_q;
  assign vid_done   = vdone_q;
  assign main_done  = mdone_q;
  assign main_rdata = rbuf;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= IDLE;
      sel_vid <= 1'b0;
      wr_q    <= 1'b0;
      addr_q  <= '0;
      cnt     <= '0;
      half_q  <= '0;
      wbuf    <= '0;
      rbuf    <= '0;
      vword_q <= '0;
      vrv_q   <= 1'b0;
      vdone_q <= 1'b0;
      mdone_q <= 1'b0;
    end else begin
      vrv_q   <= 1'b0;
      vdone_q <= 1'b0;
      mdone_q <= 1'b0;
      case (state)
        IDLE: begin
          cnt <= '0;
          if (vid_valid) begin
            sel_vid <= 1'b1;
            wr_q    <= 1'b0;
            addr_q  <= {vid_addr, 1'b0};
            state   <= CMD;
          end else if (main_valid) begin
            sel_vid <= 1'b0;
            wr_q    <= main_write;
            addr_q  <= {main_addr[WADDR_W-1:QA], {(QA+1){1'b0}}};
            wbuf    <= main_wdata;
            state   <= CMD;
          end
        end
        CMD: if (cmd_ready) state <= DATA;
        DATA: begin
          if (beat) begin
            cnt <= cnt + 1'b1;
            if (!wr_q) begin
              if (sel_vid) begin
                if (!cnt[0]) half_q <= mem_rdata;
                else begin
                  vword_q <= {mem_rdata, half_q};
                  vrv_q   <= 1'b1;
                end
              end else begin
                rbuf[int'(cnt[MBI_W-1:0])*BW +: BW] <= mem_rdata;
              end
            end
          end
          if (last) begin
            state   <= IDLE;
            vdone_q <= sel_vid;
            mdone_q <= !sel_vid;
          end
        end
        default: state <= IDLE;
      endcase
    end
  end
endmodule

module sdram_dual_arb_chk #(
  parameter int WADDR_W = 24,
  parameter int LEN_W   = 6,
  parameter int VB      = 32,
  parameter int MB      = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             vid_valid,
  input logic             vid_ready,
  input logic             main_ready,
  input logic             vid_done,
  input logic             main_done,
  input logic             vid_rvalid,
  input logic             cmd_valid,
  input logic             cmd_ready,
  input logic [WADDR_W:0] cmd_addr,
  input logic [LEN_W-1:0] cmd_len,
  input logic             mem_wvalid
);
  a_r2_video_wins: assert property (@(posedge clk) disable iff (!rst_n)
    main_ready |-> !vid_valid);
  a_r7_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
    !(vid_ready && main_ready));
  a_r7_busy_no_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid || mem_wvalid) |-> !(vid_ready || main_ready));
  a_r10_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_addr) && $stable(cmd_len)));
  a_r3_len_legal: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (cmd_len == LEN_W'(VB) || cmd_len == LEN_W'(MB)));
  a_r8_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(vid_done && main_done));
  a_r8_vdone_with_word: assert property (@(posedge clk) disable iff (!rst_n)
    vid_done |-> vid_rvalid);
  a_r1_phase_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid && mem_wvalid));
endmodule

bind sdram_dual_arb sdram_dual_arb_chk #(
  .WADDR_W(WADDR_W), .LEN_W(LEN_W), .VB(VB), .MB(MB)
) u_chk (
  .clk(clk), .rst_n(rst_n), .vid_valid(vid_valid), .vid_ready(vid_ready),
  .main_ready(main_ready), .vid_done(vid_done), .main_done(main_done),
  .vid_rvalid(vid_rvalid), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_addr(cmd_addr), .cmd_len(cmd_len), .mem_wvalid(mem_wvalid)
);

// File: tb/sdram_dual_arb_bench.sv
`timescale 1ns/1ps
module sdram_dual_arb_bench;
  localparam int AW = 24;
  localparam int MW = AW + 1;

  logic clk = 0, rst_n = 0;
  always #2.5 clk = ~clk;

  logic vid_valid = 0, main_valid = 0, main_write = 0;
  logic [AW-1:0] vid_addr = '0, main_addr = '0;
  logic [127:0] main_wdata = '0;
  logic cmd_ready = 0, mem_wready = 0, mem_rvalid = 0;
  logic [15:0] mem_rdata = '0;
  logic vid_ready, vid_rvalid, vid_done, main_ready, main_done;
  logic cmd_valid, cmd_write, mem_wvalid;
  logic [31:0] vid_rdata;
  logic [127:0] main_rdata;
  logic [MW-1:0] cmd_addr;
  logic [5:0] cmd_len;
  logic [15:0] mem_wdata;

  sdram_dual_arb u_sdram_dual_arb (
    .clk(clk), .rst_n(rst_n), .vid_valid(vid_valid), .vid_ready(vid_ready),
    .vid_addr(vid_addr), .vid_rdata(vid_rdata), .vid_rvalid(vid_rvalid),
    .vid_done(vid_done), .main_valid(main_valid), .main_ready(main_ready),
    .main_write(main_write), .main_addr(main_addr), .main_wdata(main_wdata),
    .main_rdata(main_rdata), .main_done(main_done), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_write(cmd_write), .cmd_addr(cmd_addr),
    .cmd_len(cmd_len), .mem_wdata(mem_wdata), .mem_wvalid(mem_wvalid),
    .mem_wready(mem_wready), .mem_rdata(mem_rdata), .mem_rvalid(mem_rvalid)
  );

  int tests = 0, fails = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] mv(input logic [MW-1:0] a);
    logic [31:0] x;
    x = {7'd0, a} * 32'h2545F491;
    return x[31:16] ^ x[15:0];
  endfunction

  // memory model
  logic [MW+6:0] cmd_log[$];
  logic [15:0] wlog[$];
  int r10_bad = 0;
  initial begin
    bit busy, wr, pend;
    logic [MW-1:0] base, paddr;
    int len, k;
    busy = 0; wr = 0; pend = 0; base = '0; paddr = '0; len = 0; k = 0;
    forever begin
      @(posedge clk);
      if (pend && !(cmd_valid && cmd_addr == paddr)) r10_bad++;
      pend = rst_n && cmd_valid && !cmd_ready;
      paddr = cmd_addr;
      if (!rst_n) busy = 0;
      else if (!busy) begin
        if (cmd_valid && cmd_ready) begin
          busy = 1; wr = cmd_write; base = cmd_addr; len = int'(cmd_len); k = 0;
          cmd_log.push_back({cmd_write, cmd_addr, cmd_len});
        end
      end else if (wr) begin
        if (mem_wvalid && mem_wready) begin
          wlog.push_back(mem_wdata); k++;
          if (k == len) busy = 0;
        end
      end else if (mem_rvalid) begin
        k++;
        if (k == len) busy = 0;
      end
      cmd_ready  <= !busy && ($urandom_range(0, 2) != 0);
      mem_wready <= busy && wr && ($urandom_range(0, 3) != 0);
      if (busy && !wr && ($urandom_range(0, 3) != 0)) begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= mv(base + MW'(k));
      end else begin
        mem_rvalid <= 1'b0;
      end
    end
  end

  // output monitor
  logic [31:0] vq[$];
  int vdone = 0, mdone = 0;
  logic [127:0] mlast;
  initial forever begin
    @(negedge clk);
    if (vid_rvalid) vq.push_back(vid_rdata);
    if (vid_done) vdone++;
    if (main_done) begin mdone++; mlast = main_rdata; end
  end

  task automatic tick; @(negedge clk); #2; endtask

  task automatic vid_start(input logic [AW-1:0] a);
    @(negedge clk); vid_valid = 1; vid_addr = a; #1;
    while (!vid_ready) begin @(negedge clk); #1; end
    @(negedge clk); vid_valid = 0; vid_addr = AW'($urandom);
  endtask

  task automatic main_start(input bit w, input logic [AW-1:0] a, input logic [127:0] d);
    @(negedge clk); main_valid = 1; main_write = w; main_addr = a; main_wdata = d; #1;
    while (!main_ready) begin @(negedge clk); #1; end
    @(negedge clk); main_valid = 0; main_wdata = {4{$urandom}};
  endtask

  task automatic check_cmd(input string tag, input bit w, input logic [MW-1:0] a, input int len);
    logic [MW+6:0] e;
    e = {w, a, 6'(len)};
    if (cmd_log.size() == 0) chk(0, tag, 0, e);
    else begin
      logic [MW+6:0] c;
      c = cmd_log.pop_front();
      chk(c == e, tag, c, e);
    end
  endtask

  task automatic check_vid(input logic [AW-1:0] a);
    logic [MW-1:0] b;
    int bad;
    b = {a, 1'b0};
    check_cmd("R3/R4 video cmd", 0, b, 32);
    chk(vq.size() == 16, "R8 video word count", vq.size(), 16);
    bad = 0;
    for (int i = 0; i < 16 && i < vq.size(); i++) begin
      logic [31:0] e;
      e = {mv(b + MW'(2*i+1)), mv(b + MW'(2*i))};
      if (vq[i] != e && bad == 0) begin
        chk(0, "R6/R4 video word", vq[i], e); bad = 1;
      end
    end
    if (bad == 0) chk(1, "R6 video words", 0, 0);
    vq.delete();
  endtask

  task automatic run_vid(input logic [AW-1:0] a);
    int v0, m0;
    v0 = vdone; m0 = mdone;
    vid_start(a);
    while (vdone == v0) tick;
    tick;
    chk(vdone == v0 + 1 && mdone == m0, "R8 one video done", vdone - v0, 1);
    check_vid(a);
  endtask

  task automatic run_main(input bit w, input logic [AW-1:0] a, input logic [127:0] d);
    int m0, v0;
    logic [MW-1:0] b;
    m0 = mdone; v0 = vdone;
    b = {a[AW-1:2], 3'b000};
    main_start(w, a, d);
    while (mdone == m0) tick;
    tick;
    chk(mdone == m0 + 1 && vdone == v0, "R8 one main done", mdone - m0, 1);
    check_cmd("R5 main cmd", w, b, 8);
    if (w) begin
      logic [127:0] got;
      got = '0;
      for (int k = 0; k < 8; k++) if (wlog.size() > 0) got[16*k +: 16] = wlog.pop_front();
      chk(got == d && wlog.size() == 0, "R6 write beat order", got, d);
    end else begin
      logic [127:0] e;
      for (int k = 0; k < 8; k++) e[16*k +: 16] = mv(b + MW'(k));
      chk(mlast == e, "R9 main read data", mlast, e);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    #1;
    chk(!cmd_valid && !mem_wvalid && !vid_rvalid && !vid_done && !main_done,
        "R1 reset outputs", {cmd_valid, mem_wvalid, vid_rvalid, vid_done, main_done}, 0);
    @(negedge clk); rst_n = 1;
    repeat (2) tick;
    chk(!cmd_valid && !vid_done && !main_done, "R1 idle after reset",
        {cmd_valid, vid_done, main_done}, 0);

    run_vid(24'h000000);
    run_vid(24'hFFFFFF);
    run_main(0, 24'h000007, '0);
    run_main(1, 24'hFFFFFF, 128'h0123456789ABCDEF_FEDCBA9876543210);
    run_main(0, 24'hFFFFFC, '0);

    // both request together: video must win, main waits until video done
    begin
      int viol, v0, m0;
      logic [AW-1:0] va, ma;
      va = 24'h123456; ma = 24'h00ABCD;
      viol = 0; v0 = vdone; m0 = mdone;
      @(negedge clk);
      vid_valid = 1; vid_addr = va;
      main_valid = 1; main_write = 0; main_addr = ma; #1;
      chk(vid_ready && !main_ready, "R2 video wins", {vid_ready, main_ready}, 2'b10);
      @(negedge clk); vid_valid = 0; vid_addr = ~va; #1;
      while (!vid_done) begin
        if (main_ready || vid_ready) viol++;
        @(negedge clk); #1;
      end
      chk(viol == 0, "R7 no grant mid-burst", viol, 0);
      while (!main_ready) begin @(negedge clk); #1; end
      @(negedge clk); main_valid = 0;
      while (mdone == m0) tick;
      tick;
      check_vid(va);
      check_cmd("R2 main after video", 0, {ma[AW-1:2], 3'b000}, 8);
      chk(vdone == v0 + 1 && mdone == m0 + 1, "R8 done counts", {vdone - v0, mdone - m0}, {32'd1, 32'd1});
    end

    for (int i = 0; i < 40; i++) begin
      int op;
      op = $urandom_range(0, 2);
      if (op == 0) run_vid(AW'($urandom));
      else run_main(op == 2, AW'($urandom), {$urandom, $urandom, $urandom, $urandom});
    end

    chk(r10_bad == 0, "R10 command hold", r10_bad, 0);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule